// File: doc/BRIEF.md
# Sampled Result Readout Target on I2C

This block lets an I2C bus controller fetch one 12-bit sample. A converter or another producer writes the sample into the block through a parallel port with a one-cycle valid strobe. The bus lines are oversampled by the system clock through a synchronizer. The block detects START, repeated START and STOP. It decodes the address byte and answers reads to its own 7-bit address. The upper five bits of that address are fixed and the lower two come from strap pins.

A matching read takes a snapshot of the latest sample. The block returns it as two bytes, MSB first. It watches the controller's acknowledge after every byte, and any byte requested beyond the second reads as all ones. An 8-bit result mode sends the low byte of the sample port in the first data byte. The block drives SDA through an open-drain enable only: when the enable is high, the line is pulled low. It never stretches SCL.

Top module: `i2c_sample_target`

## Requirements
- R1: While reset is high and after it falls, `sda_oe` is low and the block waits for a START.
- R2: The block pulls SDA low during the ninth clock of the address byte only when the byte is 1001 0, then `strap_a[1]`, `strap_a[0]`, then R/W = 1. A write (R/W = 0) is not acknowledged.
- R3: In 12-bit mode the first data byte is sample bits 11..4, sent MSB first.
- R4: The second data byte is sent only after the controller acknowledges the first (SDA low). In 12-bit mode it is sample bits 3..0 followed by four zero bits.
- R5: Every data byte after the second, reached by acknowledging, reads 0xFF in both modes.
- R6: When `mode_8b` is high at the address match, the first byte is `smp_data[7:0]`, the second is 0x00 and any later byte is 0xFF.
- R7: After an address that does not match, `sda_oe` stays low until the next START or repeated START.
- R8: A NACK (SDA high) from the controller after any data byte ends the transfer. SDA stays released until the next START.
- R9: The bytes sent come from the sample held at the address match. A new `smp_valid` during the transfer does not change them.
- R10: A repeated START at any point begins a new address phase, and it uses the newest sample.
- R11: A STOP at any point releases SDA, and the block returns to waiting for a START.
- R12: `sda_oe` rises only while the synchronized SCL is low. It falls only while the synchronized SCL is low, or on a detected START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_a | input | 2 | Low two address bits from strap pins |
| mode_8b | input | 1 | 1 selects the 8-bit result layout |
| smp_data | input | SMP_W | Parallel sample from the producer |
| smp_valid | input | 1 | One-cycle strobe that loads `smp_data` |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
The assertions assume that the bus moves much more slowly than the system clock. Every SCL and SDA level must be held for more than the synchronizer delay plus one cycle. SDA must change while SCL is high only to form a START or a STOP. The bench models an open-drain line that is low when either side pulls it low. It holds each bus phase for eight system clocks. It changes SDA only in the low phase of SCL, except in its start and stop tasks. It never issues a STOP while the target is holding the line low.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACKW,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_NXT,
    ST_IGNORE
  } rd_state_e;

  localparam logic [7:0] OVER_READ = 8'hFF;
endpackage

// File: rtl/i2c_rd_sync.sv
module i2c_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_now, sda_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_now  = scl_sh[STAGES-1];
  assign sda_now  = sda_sh[STAGES-1];
  assign sda_s    = sda_now;
  assign scl_rise = scl_now & ~scl_d;
  assign scl_fall = ~scl_now & scl_d;
  // data edges while clock stays high mark bus conditions
  assign start_p  = scl_now & scl_d & sda_d & ~sda_now;
  assign stop_p   = scl_now & scl_d & ~sda_d & sda_now;
endmodule

// File: rtl/i2c_rd_hold.sv
module i2c_rd_hold #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp_data,
  input  logic         smp_valid,
  input  logic         mode_i,
  input  logic         take,
  output logic [W-1:0] snap,
  output logic         snap_m8
);
  logic [W-1:0] latest;

  always_ff @(posedge clk) begin
    if (rst) begin
      latest  <= '0;
      snap    <= '0;
      snap_m8 <= 1'b0;
    end else begin
      if (smp_valid) latest <= smp_data;
      if (take) begin
        snap    <= latest;
        snap_m8 <= mode_i;
      end
    end
  end
endmodule

// File: rtl/i2c_rd_byte_sel.sv
module i2c_rd_byte_sel
  import i2c_rd_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0] snap,
  input  logic         m8,
  input  logic [1:0]   idx,
  output logic [7:0]   byte_o
);
  localparam int PAD = 16 - W;
  logic [15:0] wide, wide8;

  generate
    if (PAD == 0) begin : g_nopad
      assign wide = snap;
    end else begin : g_pad
      assign wide = {snap, {PAD{1'b0}}};
    end
  endgenerate

  assign wide8 = {snap[7:0], 8'h00};

  always_comb begin
    unique case (idx)
      2'd0:    byte_o = m8 ? wide8[15:8] : wide[15:8];
      2'd1:    byte_o = m8 ? wide8[7:0]  : wide[7:0];
      default: byte_o = OVER_READ;
    endcase
  end
endmodule

// File: rtl/i2c_sample_target.sv
module i2c_sample_target
  import i2c_rd_pkg::*;
#(
  parameter int         SMP_W       = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_HI     = 5'b10010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [1:0]       strap_a,
  input  logic             mode_8b,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             smp_valid,
  output logic             sda_oe
);
  logic sda_s, scl_rise, scl_fall, start_p, stop_p;
  rd_state_e state;
  logic [7:0] sh, tx_byte, addr_byte;
  logic [2:0] bcnt;
  logic [1:0] bidx;
  logic addr_ok, take;
  logic [SMP_W-1:0] snap_q;
  logic snap_m8;

  i2c_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  i2c_rd_hold #(.W(SMP_W)) u_hold (
    .clk(clk), .rst(rst), .smp_data(smp_data), .smp_valid(smp_valid),
    .mode_i(mode_8b), .take(take), .snap(snap_q), .snap_m8(snap_m8)
  );

  i2c_rd_byte_sel #(.W(SMP_W)) u_sel (
    .snap(snap_q), .m8(snap_m8), .idx(bidx), .byte_o(tx_byte)
  );

  assign addr_byte = {sh[6:0], sda_s};
  assign addr_ok   = (addr_byte[7:1] == {ADDR_HI, strap_a}) && addr_byte[0];
  assign take      = (state == ST_ADDR) && scl_rise && (bcnt == 3'd7) && addr_ok
                     && !start_p && !stop_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
      sh     <= '0;
      bcnt   <= '0;
      bidx   <= '0;
    end else if (start_p) begin
      state  <= ST_ADDR;
      sda_oe <= 1'b0;
      bcnt   <= '0;
      bidx   <= '0;
    end else if (stop_p) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: if (scl_rise) begin
          sh   <= addr_byte;
          bcnt <= bcnt + 3'd1;
          if (bcnt == 3'd7) state <= addr_ok ? ST_ACKW : ST_IGNORE;
        end
        ST_ACKW: if (scl_fall) begin
          sda_oe <= 1'b1;
          state  <= ST_ACK;
        end
        ST_ACK, ST_NXT: if (scl_fall) begin
          sh     <= tx_byte;
          sda_oe <= ~tx_byte[7];
          bcnt   <= '0;
          state  <= ST_TX;
        end
        ST_TX: if (scl_fall) begin
          if (bcnt == 3'd7) begin
            sda_oe <= 1'b0;
            state  <= ST_RACK;
            bidx   <= (bidx == 2'd2) ? 2'd2 : bidx + 2'd1;
          end else begin
            sh     <= {sh[6:0], 1'b0};
            sda_oe <= ~sh[6];
            bcnt   <= bcnt + 3'd1;
          end
        end
        ST_RACK: if (scl_rise) state <= sda_s ? ST_IGNORE : ST_NXT;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rd_chk.sv
module i2c_rd_chk
  import i2c_rd_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_i,
  input logic             sda_i,
  input logic             sda_oe,
  input rd_state_e        state,
  input logic [SMP_W-1:0] snap_q
);
  logic [1:0] c_scl, c_sda;
  logic c_scl_d, c_sda_d, c_start, c_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_scl <= '1; c_sda <= '1; c_scl_d <= 1'b1; c_sda_d <= 1'b1;
    end else begin
      c_scl <= {c_scl[0], scl_i};
      c_sda <= {c_sda[0], sda_i};
      c_scl_d <= c_scl[1];
      c_sda_d <= c_sda[1];
    end
  end
  assign c_start = c_scl[1] & c_scl_d & c_sda_d & ~c_sda[1];
  assign c_stop  = c_scl[1] & c_scl_d & ~c_sda_d & c_sda[1];

  a_r1_reset_release: assert property (@(posedge clk) $past(rst) |-> !sda_oe);
  a_r2_ack_drives: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK) |-> sda_oe);
  a_r7_ignore_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_oe);
  a_r9_snap_stable: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX) |-> $stable(snap_q));
  a_r11_stop_release: assert property (@(posedge clk) disable iff (rst)
    c_stop |=> (!sda_oe && state == ST_IDLE));
  a_r12_rise_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(c_scl[1]));
  a_r12_fall_scl_low: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> (!$past(c_scl[1]) || $past(c_start) || $past(c_stop)));
endmodule

bind i2c_sample_target i2c_rd_chk #(.SMP_W(SMP_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe(sda_oe), .state(state), .snap_q(snap_q)
);

// File: tb/i2c_sample_target_tb.sv
module i2c_sample_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic m_scl = 1'b1, m_sda_low = 1'b0;
  logic [1:0] strap = 2'b01;
  logic mode8 = 1'b0;
  logic [11:0] smp = '0;
  logic smp_v = 1'b0;
  logic sda_oe;
  wire sda_line = !(m_sda_low || sda_oe);

  logic [11:0] cur_smp = '0;
  logic [7:0] exp_q[$];
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_sample_target u_dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .strap_a(strap),
    .mode_8b(mode8), .smp_data(smp), .smp_valid(smp_v), .sda_oe(sda_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor side of the scoreboard
  task automatic mon_byte(input logic [7:0] got, input string req);
    logic [7:0] e;
    if (exp_q.size() == 0) begin
      check(1'b0, req, got, 0);
    end else begin
      e = exp_q.pop_front();
      check(got == e, req, got, e);
    end
  endtask

  function automatic logic [7:0] model(input int idx, input logic [11:0] s, input bit m8);
    if (idx >= 2) return 8'hFF;
    if (m8) return (idx == 0) ? s[7:0] : 8'h00;
    return (idx == 0) ? s[11:4] : {s[3:0], 4'h0};
  endfunction

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic load(input logic [11:0] v);
    @(negedge clk); smp = v; smp_v = 1'b1;
    @(negedge clk); smp_v = 1'b0;
    cur_smp = v;
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; qw(); m_scl = 1'b1; qw();
    m_sda_low = 1'b1; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; qw(); m_scl = 1'b1; qw();
    m_sda_low = 1'b0; qw();
  endtask

  task automatic wbit(input logic b);
    m_sda_low = !b; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
  endtask

  task automatic rbit(output logic b);
    m_sda_low = 1'b0; qw(); m_scl = 1'b1; qw(); b = sda_line; qw();
    m_scl = 1'b0; qw();
  endtask

  // driver: pushes expected bytes, then runs one read on the bus
  task automatic rd_txn(input logic [6:0] a7, input logic rw, input int n,
                        input logic [3:0] nack_mask, input bit do_stop, input string req);
    bit match, nacked;
    logic ackb, b;
    logic [7:0] got;
    match = (a7 == {5'b10010, strap}) && rw;
    nacked = 0;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back((match && !nacked) ? model(i, cur_smp, mode8) : 8'hFF);
      if (nack_mask[i]) nacked = 1;
    end
    bus_start();
    for (int i = 6; i >= 0; i--) wbit(a7[i]);
    wbit(rw);
    rbit(ackb);
    check(ackb == !match, {req, " addr ack"}, ackb, !match);
    for (int i = 0; i < n; i++) begin
      for (int k = 7; k >= 0; k--) begin rbit(b); got[k] = b; end
      wbit(nack_mask[i]);
      mon_byte(got, req);
    end
    if (do_stop) bus_stop();
  endtask

  initial begin
    repeat (Q * 150000 / 8) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic b;
    repeat (10) @(negedge clk);
    check(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);

    load(12'hABC);
    rd_txn({5'b10010, 2'b01}, 1'b1, 2, 4'b0010, 1, "R2 R3 R4 12-bit read");
    rd_txn({5'b10010, 2'b10}, 1'b1, 1, 4'b0001, 1, "R7 mismatch");
    rd_txn({5'b10010, 2'b01}, 1'b0, 0, 4'b0000, 1, "R2 write not acked");
    rd_txn({5'b10010, 2'b01}, 1'b1, 4, 4'b1000, 1, "R5 over-read");
    rd_txn({5'b10010, 2'b01}, 1'b1, 3, 4'b0101, 1, "R8 nack aborts");

    mode8 = 1'b1;
    load(12'h3C5);
    rd_txn({5'b10010, 2'b01}, 1'b1, 3, 4'b0100, 1, "R6 8-bit mode");
    mode8 = 1'b0;

    load(12'h123);
    fork
      rd_txn({5'b10010, 2'b01}, 1'b1, 2, 4'b0010, 0, "R9 hold at match");
      begin repeat (Q * 50) @(negedge clk); smp = 12'hFFF; smp_v = 1'b1;
            @(negedge clk); smp_v = 1'b0; end
    join
    cur_smp = 12'hFFF;
    rd_txn({5'b10010, 2'b01}, 1'b1, 2, 4'b0010, 1, "R10 repeated start");

    load(12'hF05);
    bus_start();
    for (int i = 6; i >= 0; i--) wbit(7'b1001001 >> i);
    wbit(1'b1);
    rbit(b);
    check(b == 1'b0, "R11 addr ack", b, 0);
    for (int k = 0; k < 3; k++) rbit(b);
    bus_stop();
    repeat (6) @(negedge clk);
    check(sda_oe == 1'b0, "R11 release on stop", sda_oe, 0);
    rd_txn({5'b10010, 2'b01}, 1'b1, 2, 4'b0010, 1, "R11 read after stop");

    strap = 2'b11;
    rd_txn({5'b10010, 2'b11}, 1'b1, 2, 4'b0010, 1, "R2 strap 11");
    rd_txn({5'b10010, 2'b01}, 1'b1, 1, 4'b0001, 1, "R7 old strap");

    check(exp_q.size() == 0, "R12 scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule